// File: doc/BRIEF.md
# Bus Error Capture and Interrupt

This block sits beside an on-chip register-access interconnect and watches two event inputs. One is an error acknowledge returned by a target. The other is a one-cycle timeout pulse from a separate transaction timer. An event is accepted unless the transfer in flight is a full-word read by the main processor initiator. Errors on those reads are dropped without a trace, so that speculative loads never fault.

An accepted event does three things:

- It sets a sticky status bit for its source.
- It raises a gated error indication back to the target for that cycle.
- If the capture is not locked, it latches the transaction's address, read flag, byte mask and initiator ID. The capture then stays frozen until software clears every status bit.

Software uses a small word-indexed register port to do the following:

- Read status and capture contents.
- Set the per-source interrupt enables.
- Clear status bits by writing ones.
- Force status bits by writing ones.

The interrupt line is the OR over both sources of status AND enable.

Top module: `bus_err_capture`

## Requirements
- R1: After reset, status, enable, the lock and all capture fields are zero, `irq` is low and `err_out` is low with quiet inputs.
- R2: The transfer is suppressed when `txn_init` equals `CPU_ID`, `txn_rd` is 1 and every bit of `txn_mask` is 1. Otherwise, a cycle with `err_ack` high sets status bit 0 and a cycle with `tmo` high sets status bit 1, visible after that clock edge.
- R3: When an event is accepted and the capture is unlocked, the capture registers take `txn_addr`, `txn_rd`, `txn_mask` and `txn_init` at that edge, and the capture locks.
- R4: While locked, the capture fields do not change on further events. The lock is released only when a write leaves both status bits zero; the next accepted event then captures again.
- R5: For a suppressed transfer, `err_ack` and `tmo` leave the status, the capture fields and `err_out` untouched.
- R6: `err_out` is high in exactly the cycles where `err_ack` or `tmo` is high and the transfer is not suppressed (combinational, no delay).
- R7: `irq` is high exactly when (status AND enable) is nonzero. Enable is word index 1, bits [1:0], read/write.
- R8: Writing word index 0 clears each status bit whose data bit is 1. A clear and a new event for the same bit in the same cycle leave that bit set.
- R9: Writing word index 2 sets each status bit whose data bit is 1 at that edge, without touching the capture. Index 2 reads as zero.
- R10: Read data is combinational on `reg_addr`: index 0 gives status in bits [1:0], index 1 gives enable in bits [1:0], index 3 gives the captured address. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_ack | input | 1 | Error acknowledge seen on the interconnect |
| tmo | input | 1 | Timeout pulse from the transaction timer |
| txn_addr | input | AW | Address of the transfer in flight |
| txn_rd | input | 1 | 1 = read, 0 = write |
| txn_mask | input | MW | Byte mask of the transfer |
| txn_init | input | IW | Granted initiator ID |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request |
| err_out | output | 1 | Gated error indication to the target |
| cap_addr | output | AW | Captured address |
| cap_rd | output | 1 | Captured read flag |
| cap_mask | output | MW | Captured byte mask |
| cap_init | output | IW | Captured initiator ID |

## Verification
The main sweep covers every combination of initiator ID, read flag, byte mask and event source for a 2-bit ID and 4-bit mask. This separates the single suppressed pattern from its near neighbours: a processor write, a processor partial read, and a full read by another initiator. After each accepted event, a second event with a different address shows whether the capture froze. The clear that follows shows whether the lock was released. Separate sequences try each enable with forced status bits, and a clear landing in the same cycle as a new event, to tell the sticky-set priority from the clear.

// File: rtl/bus_err_capture.sv
module bus_err_capture #(
  parameter int AW = 32,
  parameter int MW = 4,
  parameter int IW = 2,
  parameter int CPU_ID = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_ack,
  input  logic          tmo,
  input  logic [AW-1:0] txn_addr,
  input  logic          txn_rd,
  input  logic [MW-1:0] txn_mask,
  input  logic [IW-1:0] txn_init,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          err_out,
  output logic [AW-1:0] cap_addr,
  output logic          cap_rd,
  output logic [MW-1:0] cap_mask,
  output logic [IW-1:0] cap_init
);
  localparam logic [IW-1:0] CPU = IW'(CPU_ID);

  logic [1:0] st, en, st_n, clr, set, ev;
  logic       lock, blk;

  assign blk = (txn_init == CPU) && txn_rd && (&txn_mask);
  assign ev  = {tmo, err_ack} & {2{~blk}};
  assign clr = (reg_wr && reg_addr == 2'd0) ? reg_wdata[1:0] : 2'b00;
  assign set = (reg_wr && reg_addr == 2'd2) ? reg_wdata[1:0] : 2'b00;
  assign st_n = (st & ~clr) | set | ev;

  assign err_out = |ev;
  assign irq     = |(st & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= '0;
      en   <= '0;
      lock <= 1'b0;
    end else begin
      st   <= st_n;
      lock <= (|ev) | (lock & (|st_n));
      if (reg_wr && reg_addr == 2'd1) en <= reg_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_rd   <= 1'b0;
      cap_mask <= '0;
      cap_init <= '0;
    end else if ((|ev) && !lock) begin
      cap_addr <= txn_addr;
      cap_rd   <= txn_rd;
      cap_mask <= txn_mask;
      cap_init <= txn_init;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0:    reg_rdata[1:0] = st;
      2'd1:    reg_rdata[1:0] = en;
      2'd3:    reg_rdata = 32'(cap_addr);
      default: reg_rdata = '0;
    endcase
  end
endmodule

module bus_err_capture_chk #(
  parameter int AW = 32,
  parameter int MW = 4,
  parameter int IW = 2,
  parameter int CPU_ID = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          err_ack,
  input logic          tmo,
  input logic          txn_rd,
  input logic [MW-1:0] txn_mask,
  input logic [IW-1:0] txn_init,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic          irq,
  input logic          err_out,
  input logic [AW-1:0] cap_addr,
  input logic [1:0]    st,
  input logic [1:0]    en,
  input logic          lock
);
  logic sup;
  assign sup = (txn_init == IW'(CPU_ID)) && txn_rd && (&txn_mask);

  // R6
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_out |-> (err_ack || tmo));
  // R5
  sup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sup |-> !err_out);
  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ack && !sup) |=> st[0]);
  // R2
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !sup) |=> st[1]);
  // R4
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(cap_addr));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 2'b00) |-> !irq);
  // R8
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st[0] && !(reg_wr && reg_addr == 2'd0)) |=> st[0]);
endmodule

bind bus_err_capture bus_err_capture_chk #(
  .AW(AW), .MW(MW), .IW(IW), .CPU_ID(CPU_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .err_ack(err_ack), .tmo(tmo),
  .txn_rd(txn_rd), .txn_mask(txn_mask), .txn_init(txn_init),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .irq(irq), .err_out(err_out),
  .cap_addr(cap_addr), .st(st), .en(en), .lock(lock)
);

// File: tb/bus_err_capture_test.sv
module bus_err_capture_test;
  localparam int AW = 32, MW = 4, IW = 2, CPU_ID = 0;

  logic clk = 0, rst_n = 0;
  logic err_ack = 0, tmo = 0, txn_rd = 0, reg_wr = 0;
  logic [AW-1:0] txn_addr = '0;
  logic [MW-1:0] txn_mask = '0;
  logic [IW-1:0] txn_init = '0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, err_out, cap_rd;
  logic [AW-1:0] cap_addr;
  logic [MW-1:0] cap_mask;
  logic [IW-1:0] cap_init;

  int checks = 0, errors = 0;
  logic [AW-1:0] e_addr = '0;
  logic          e_rd = 0;
  logic [MW-1:0] e_mask = '0;
  logic [IW-1:0] e_init = '0;

  always #2.5 clk = ~clk;

  bus_err_capture #(.AW(AW), .MW(MW), .IW(IW), .CPU_ID(CPU_ID)) uut (
    .clk(clk), .rst_n(rst_n), .err_ack(err_ack), .tmo(tmo),
    .txn_addr(txn_addr), .txn_rd(txn_rd), .txn_mask(txn_mask),
    .txn_init(txn_init), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .err_out(err_out), .cap_addr(cap_addr), .cap_rd(cap_rd),
    .cap_mask(cap_mask), .cap_init(cap_init)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic chk_cap(input string tag);
    chk(cap_addr == e_addr, tag, 64'(cap_addr), 64'(e_addr));
    chk({cap_rd, cap_mask, cap_init} == {e_rd, e_mask, e_init}, tag,
        64'({cap_rd, cap_mask, cap_init}), 64'({e_rd, e_mask, e_init}));
  endtask

  task automatic fire(input bit src, input logic [AW-1:0] a, input bit r,
                      input logic [MW-1:0] m, input logic [IW-1:0] i,
                      output bit sup);
    @(negedge clk);
    txn_addr = a; txn_rd = r; txn_mask = m; txn_init = i;
    err_ack = !src; tmo = src;
    sup = (i == IW'(CPU_ID)) && r && (m == '1);
    #0.5;
    chk(err_out == !sup, sup ? "R5 err_out" : "R6 err_out",
        64'(err_out), 64'(!sup));
    @(negedge clk);
    err_ack = 0; tmo = 0;
    #0.5;
    chk(err_out == 0, "R6 one cycle", 64'(err_out), 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit sup, s2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.5;
    // R1
    rd_reg(0, d); chk(d == 0, "R1 status", 64'(d), 0);
    rd_reg(1, d); chk(d == 0, "R1 enable", 64'(d), 0);
    chk(irq == 0 && err_out == 0, "R1 outputs", 64'({irq, err_out}), 0);
    chk_cap("R1 capture");

    // R2 R3 R4 R5 R6: sweep of initiator, direction, mask, source
    for (int i = 0; i < (1 << IW); i++)
      for (int r = 0; r < 2; r++)
        for (int m = 0; m < (1 << MW); m++)
          for (int s = 0; s < 2; s++) begin
            logic [AW-1:0] a;
            a = 32'hA500_0000 | 32'(i << 12 | r << 8 | m << 4 | s);
            fire(s[0], a, r[0], m[MW-1:0], i[IW-1:0], sup);
            rd_reg(0, d);
            if (sup) begin
              chk(d == 0, "R5 status", 64'(d), 0);
              chk_cap("R5 capture");
            end else begin
              chk(d == (32'd1 << s), "R2 status", 64'(d), 64'(32'd1 << s));
              e_addr = a; e_rd = r[0]; e_mask = m[MW-1:0]; e_init = i[IW-1:0];
              chk_cap("R3 capture");
              rd_reg(3, d); chk(d == a, "R10 cap read", 64'(d), 64'(a));
              fire(!s[0], ~a, 1'b0, '0, IW'(CPU_ID + 1), s2);
              chk_cap("R4 frozen");
              rd_reg(0, d); chk(d == 3, "R2 both bits", 64'(d), 3);
              wr_reg(0, 32'h1);
              fire(s[0], a ^ 32'hFF, 1'b0, '0, IW'(CPU_ID + 1), s2);
              chk_cap("R4 partial clear keeps lock");
              wr_reg(0, 32'h3);
              #0.5;
              rd_reg(0, d); chk(d == 0, "R8 cleared", 64'(d), 0);
            end
          end

    // R4: released lock captures again
    fire(1'b0, 32'h1234_5678, 1'b1, 4'h3, 2'd2, sup);
    e_addr = 32'h1234_5678; e_rd = 1; e_mask = 4'h3; e_init = 2'd2;
    chk_cap("R4 recapture");
    wr_reg(0, 32'h3);

    // R7 R9: software set and enables
    wr_reg(2, 32'h1);
    #0.5;
    rd_reg(0, d); chk(d == 1, "R9 set", 64'(d), 1);
    rd_reg(2, d); chk(d == 0, "R9 read zero", 64'(d), 0);
    chk(irq == 0, "R7 disabled", 64'(irq), 0);
    chk_cap("R9 capture untouched");
    wr_reg(1, 32'h2);
    #0.5;
    chk(irq == 0, "R7 other enable", 64'(irq), 0);
    rd_reg(1, d); chk(d == 2, "R10 enable read", 64'(d), 2);
    wr_reg(2, 32'h2);
    #0.5;
    chk(irq == 1, "R7 enabled", 64'(irq), 1);
    wr_reg(0, 32'h2);
    #0.5;
    chk(irq == 0, "R7 after clear", 64'(irq), 0);
    wr_reg(1, 32'h3);
    #0.5;
    chk(irq == 1, "R7 bit0 pending", 64'(irq), 1);
    wr_reg(0, 32'h1);

    // R8: clear and event in the same cycle
    @(negedge clk);
    err_ack = 1; txn_init = 2'd1; txn_rd = 0; txn_addr = 32'hCAFE_0001;
    @(negedge clk);
    err_ack = 0;
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'h1; err_ack = 1;
    @(negedge clk);
    reg_wr = 0; err_ack = 0;
    #0.5;
    rd_reg(0, d); chk(d == 1, "R8 clear vs event", 64'(d), 1);
    chk(irq == 1, "R7 irq after race", 64'(irq), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule